// File: doc/BRIEF.md
# Two-Level Indirect Branch Target Predictor

This block supplies predicted targets for indirect branches and returns in a fetch unit. Each fetch PC goes to two target tables at the same time. The first table is small and fully associative. When it holds the PC, it returns the target in the same cycle, so fetch loses no cycle. The second table is a larger set-associative array. When only the second table holds the PC, the target comes out one cycle later. In that same cycle the entry is copied into the first table, so the next fetch of that PC pays no penalty.

When the execute stage resolves a branch, it writes the corrected target into both tables. A return-address stack handles calls and returns. A call hint pushes the return address and a return hint pops it. When the stack holds nothing, the block says so instead of giving a stale address. After a mispredict, a flush restores the stack pointer and the depth from the checkpoint that the front end captured when it predicted the branch.

Top module: `ind_tgt_pred`

## Requirements
- R1: After reset, `fast_hit_o`, `slow_hit_o` and `ras_valid_o` are 0, and `ras_ptr_o` and `ras_cnt_o` are 0.
- R2: A lookup whose PC is held in the first table raises `fast_hit_o` with the stored target in the same cycle, and `slow_hit_o` stays low in the following cycle.
- R3: A lookup whose PC is missing from the first table but held in the second table leaves `fast_hit_o` low. In the next cycle it raises `slow_hit_o` with the stored target. A PC held in neither table raises neither output.
- R4: A second-table-only hit copies the entry into the first table in the cycle `slow_hit_o` is high, unless an update is written in that cycle. A lookup of the same PC after that cycle is a first-table hit.
- R5: An update writes the PC and target into both tables. Once the first table has evicted it, a lookup still finds it in the second table.
- R6: The first table holds `L1_N` entries. It fills invalid slots first and then replaces the least recently used entry. A lookup hit counts as a use.
- R7: An update to a PC already held overwrites its target in place.
- R8: A call pushes its return address, which becomes `ras_tgt_o` with `ras_valid_o` high. A return pops, and addresses come back last in, first out.
- R9: More than `RAS_N` pushes wrap the pointer and overwrite the oldest entry, with the depth saturating at `RAS_N`. When the depth is 0, `ras_valid_o` is low and a return leaves the depth at 0.
- R10: A flush loads the stack pointer and depth from `flush_ptr_i` and `flush_cnt_i`, takes priority over call and return, and the top of the stack then reads the entry just below the restored pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Fetch lookup request |
| lookup_pc_i | input | 32 | Fetch PC |
| fast_hit_o | output | 1 | First-table hit, same cycle |
| fast_tgt_o | output | 32 | First-table target |
| slow_hit_o | output | 1 | Second-table-only hit for the previous cycle's lookup |
| slow_tgt_o | output | 32 | Second-table target |
| upd_valid_i | input | 1 | Resolved-branch update |
| upd_pc_i | input | 32 | Branch PC to update |
| upd_tgt_i | input | 32 | Resolved target |
| call_i | input | 1 | Push hint |
| call_addr_i | input | 32 | Return address to push |
| ret_i | input | 1 | Pop hint |
| flush_i | input | 1 | Restore the stack from the checkpoint |
| flush_ptr_i | input | 4 | Checkpoint pointer |
| flush_cnt_i | input | 5 | Checkpoint depth |
| ras_valid_o | output | 1 | Stack holds a prediction |
| ras_tgt_o | output | 32 | Top-of-stack address |
| ras_ptr_o | output | 4 | Current pointer, captured as a checkpoint |
| ras_cnt_o | output | 5 | Current depth, captured as a checkpoint |

## Verification
The hardest case to reach is a PC that the second table holds but the first table does not, because every update writes both tables. The stimulus first writes the victim PC. It then writes sixteen other PCs that map to other second-table sets, which pushes the victim out of the first table as least recently used while its second-table copy stays intact. The next lookup of the victim must then come back late, and the lookup after that must come back in the same cycle. Stack wrap-around is reached by pushing one more address than the depth and then popping the stack past empty.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
  parameter int unsigned IBT_PC_W = 32;
  typedef logic [IBT_PC_W-1:0] pc_t;

  typedef struct packed {
    logic en;
    pc_t  pc;
    pc_t  tgt;
  } ibt_wr_t;
endpackage

// File: rtl/ibt_l1.sv
module ibt_l1
  import ibt_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rd_en_i,
  input  pc_t     rd_pc_i,
  output logic    hit_o,
  output pc_t     tgt_o,
  input  ibt_wr_t wr_i
);
  localparam int unsigned AW = $clog2(N);

  logic [N-1:0]  vld_q;
  pc_t           pc_q  [N];
  pc_t           tgt_q [N];
  logic [AW-1:0] age_q [N];

  logic [N-1:0]  rd_match, wr_match;
  logic [AW-1:0] rd_idx, wr_idx, free_idx, old_idx, touch_idx;
  logic          free_any, wr_hit, touch_en;

  always_comb begin
    rd_match = '0;
    wr_match = '0;
    rd_idx   = '0;
    tgt_o    = '0;
    for (int i = 0; i < N; i++) begin
      rd_match[i] = vld_q[i] && (pc_q[i] == rd_pc_i);
      wr_match[i] = vld_q[i] && (pc_q[i] == wr_i.pc);
      if (rd_match[i]) begin
        rd_idx = AW'(i);
        tgt_o  = tgt_q[i];
      end
    end
    hit_o = rd_en_i && (|rd_match);
  end

  // write slot: existing entry, else lowest free, else LRU
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    wr_hit   = 1'b0;
    wr_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = AW'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == AW'(N - 1)) old_idx = AW'(i);
      if (wr_match[i]) begin
        wr_hit = 1'b1;
        wr_idx = AW'(i);
      end
    end
    if (!wr_hit) wr_idx = free_any ? free_idx : old_idx;
    touch_en  = wr_i.en || hit_o;
    touch_idx = wr_i.en ? wr_idx : rd_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else begin
      if (wr_i.en) vld_q[wr_idx] <= 1'b1;
      if (touch_en) begin
        for (int i = 0; i < N; i++) begin
          if (AW'(i) == touch_idx)              age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i.en) begin
      pc_q[wr_idx]  <= wr_i.pc;
      tgt_q[wr_idx] <= wr_i.tgt;
    end
  end
endmodule

// File: rtl/ibt_l2.sv
module ibt_l2
  import ibt_pkg::*;
#(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rd_en_i,
  input  pc_t     rd_pc_i,
  output logic    hit_o,
  output pc_t     pc_o,
  output pc_t     tgt_o,
  input  ibt_wr_t wr_i
);
  localparam int unsigned IW = $clog2(SETS);
  localparam int unsigned WW = $clog2(WAYS);
  localparam int unsigned TW = IBT_PC_W - IW;

  logic          vld_q [SETS][WAYS];
  logic [TW-1:0] tag_q [SETS][WAYS];
  pc_t           tgt_q [SETS][WAYS];
  logic [WW-1:0] rr_q  [SETS];

  logic [IW-1:0] rd_set, wr_set;
  logic [TW-1:0] rd_tag, wr_tag;
  logic          rd_hit, wr_hit, free_any;
  pc_t           rd_tgt;
  logic [WW-1:0] wr_way, free_way;

  assign rd_set = rd_pc_i[IW-1:0];
  assign rd_tag = rd_pc_i[IBT_PC_W-1:IW];
  assign wr_set = wr_i.pc[IW-1:0];
  assign wr_tag = wr_i.pc[IBT_PC_W-1:IW];

  always_comb begin
    rd_hit   = 1'b0;
    rd_tgt   = '0;
    wr_hit   = 1'b0;
    wr_way   = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[rd_set][w] && tag_q[rd_set][w] == rd_tag) begin
        rd_hit = 1'b1;
        rd_tgt = tgt_q[rd_set][w];
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[wr_set][w]) begin
        free_any = 1'b1;
        free_way = WW'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[wr_set][w] && tag_q[wr_set][w] == wr_tag) begin
        wr_hit = 1'b1;
        wr_way = WW'(w);
      end
    end
    if (!wr_hit) wr_way = free_any ? free_way : rr_q[wr_set];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
      end
    end else begin
      hit_o <= rd_en_i && rd_hit;
      if (wr_i.en) begin
        vld_q[wr_set][wr_way] <= 1'b1;
        if (!wr_hit && !free_any) rr_q[wr_set] <= rr_q[wr_set] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    pc_o  <= rd_pc_i;
    tgt_o <= rd_tgt;
    if (wr_i.en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      tgt_q[wr_set][wr_way] <= wr_i.tgt;
    end
  end
endmodule

// File: rtl/ibt_ras.sv
module ibt_ras
  import ibt_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned PW = $clog2(N),
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  pc_t           push_addr_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [PW-1:0] flush_ptr_i,
  input  logic [CW-1:0] flush_cnt_i,
  output logic          valid_o,
  output pc_t           tgt_o,
  output logic [PW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o
);
  pc_t           stk_q [N];
  logic [PW-1:0] ptr_q, top_idx, wr_idx;
  logic [CW-1:0] cnt_q;
  logic          empty, wr_en;

  assign top_idx = ptr_q - 1'b1;
  assign empty   = (cnt_q == '0);
  assign valid_o = !empty;
  assign tgt_o   = stk_q[top_idx];
  assign ptr_o   = ptr_q;
  assign cnt_o   = cnt_q;

  // push with pop on a non-empty stack replaces the top
  always_comb begin
    wr_en  = !flush_i && push_i;
    wr_idx = (pop_i && !empty) ? top_idx : ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      ptr_q <= flush_ptr_i;
      cnt_q <= flush_cnt_i;
    end else if (push_i && !(pop_i && !empty)) begin
      ptr_q <= ptr_q + 1'b1;
      if (cnt_q != CW'(N)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !push_i && !empty) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) stk_q[wr_idx] <= push_addr_i;
  end
endmodule

// File: rtl/ind_tgt_pred.sv
module ind_tgt_pred
  import ibt_pkg::*;
#(
  parameter int unsigned L1_N    = 16,
  parameter int unsigned L2_SETS = 64,
  parameter int unsigned L2_WAYS = 4,
  parameter int unsigned RAS_N   = 16,
  localparam int unsigned RAS_PW = $clog2(RAS_N),
  localparam int unsigned RAS_CW = $clog2(RAS_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [31:0]       lookup_pc_i,
  output logic              fast_hit_o,
  output logic [31:0]       fast_tgt_o,
  output logic              slow_hit_o,
  output logic [31:0]       slow_tgt_o,
  input  logic              upd_valid_i,
  input  logic [31:0]       upd_pc_i,
  input  logic [31:0]       upd_tgt_i,
  input  logic              call_i,
  input  logic [31:0]       call_addr_i,
  input  logic              ret_i,
  input  logic              flush_i,
  input  logic [RAS_PW-1:0] flush_ptr_i,
  input  logic [RAS_CW-1:0] flush_cnt_i,
  output logic              ras_valid_o,
  output logic [31:0]       ras_tgt_o,
  output logic [RAS_PW-1:0] ras_ptr_o,
  output logic [RAS_CW-1:0] ras_cnt_o
);
  ibt_wr_t l1_wr, l2_wr;
  pc_t     slow_pc;

  assign l2_wr = '{en: upd_valid_i, pc: upd_pc_i, tgt: upd_tgt_i};

  // update wins over promotion
  always_comb begin
    if (upd_valid_i)     l1_wr = l2_wr;
    else if (slow_hit_o) l1_wr = '{en: 1'b1, pc: slow_pc, tgt: slow_tgt_o};
    else                 l1_wr = '0;
  end

  ibt_l1 #(.N(L1_N)) u_l1 (
    .clk_i, .rst_ni,
    .rd_en_i (lookup_valid_i),
    .rd_pc_i (lookup_pc_i),
    .hit_o   (fast_hit_o),
    .tgt_o   (fast_tgt_o),
    .wr_i    (l1_wr)
  );

  ibt_l2 #(.SETS(L2_SETS), .WAYS(L2_WAYS)) u_l2 (
    .clk_i, .rst_ni,
    .rd_en_i (lookup_valid_i && !fast_hit_o),
    .rd_pc_i (lookup_pc_i),
    .hit_o   (slow_hit_o),
    .pc_o    (slow_pc),
    .tgt_o   (slow_tgt_o),
    .wr_i    (l2_wr)
  );

  ibt_ras #(.N(RAS_N)) u_ras (
    .clk_i, .rst_ni,
    .push_i      (call_i),
    .push_addr_i (call_addr_i),
    .pop_i       (ret_i),
    .flush_i, .flush_ptr_i, .flush_cnt_i,
    .valid_o     (ras_valid_o),
    .tgt_o       (ras_tgt_o),
    .ptr_o       (ras_ptr_o),
    .cnt_o       (ras_cnt_o)
  );
endmodule

// File: rtl/ibt_pred_chk.sv
module ibt_pred_chk #(
  parameter int unsigned RAS_N  = 16,
  parameter int unsigned RAS_PW = $clog2(RAS_N),
  parameter int unsigned RAS_CW = $clog2(RAS_N + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_valid_i,
  input logic [31:0]       lookup_pc_i,
  input logic              fast_hit_o,
  input logic [31:0]       fast_tgt_o,
  input logic              slow_hit_o,
  input logic              upd_valid_i,
  input logic [31:0]       upd_pc_i,
  input logic [31:0]       upd_tgt_i,
  input logic              call_i,
  input logic [31:0]       call_addr_i,
  input logic              ret_i,
  input logic              flush_i,
  input logic [RAS_PW-1:0] flush_ptr_i,
  input logic [RAS_CW-1:0] flush_cnt_i,
  input logic              ras_valid_o,
  input logic [31:0]       ras_tgt_o,
  input logic [RAS_PW-1:0] ras_ptr_o,
  input logic [RAS_CW-1:0] ras_cnt_o
);
  p_slow_after_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_hit_o |-> ($past(lookup_valid_i) && !$past(fast_hit_o)));

  p_upd_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (!(lookup_valid_i && lookup_pc_i == $past(upd_pc_i))
                     || (fast_hit_o && fast_tgt_o == $past(upd_tgt_i))));

  p_push_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !flush_i) |=> (ras_valid_o && ras_tgt_o == $past(call_addr_i)));

  p_depth_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !$isunknown(ras_cnt_o)) |=> (ras_cnt_o <= RAS_CW'(RAS_N)));

  p_empty_invalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_cnt_o == '0) |-> !ras_valid_o);

  p_pop_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !flush_i && ras_cnt_o == '0) |=> (ras_cnt_o == '0));

  p_flush_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (ras_ptr_o == $past(flush_ptr_i) && ras_cnt_o == $past(flush_cnt_i)));
endmodule

bind ind_tgt_pred ibt_pred_chk #(.RAS_N(RAS_N)) u_chk (
  .clk_i, .rst_ni, .lookup_valid_i, .lookup_pc_i, .fast_hit_o, .fast_tgt_o,
  .slow_hit_o, .upd_valid_i, .upd_pc_i, .upd_tgt_i, .call_i, .call_addr_i,
  .ret_i, .flush_i, .flush_ptr_i, .flush_cnt_i, .ras_valid_o, .ras_tgt_o,
  .ras_ptr_o, .ras_cnt_o
);

// File: tb/ind_tgt_pred_test.sv
module ind_tgt_pred_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        fast_hit, slow_hit;
  logic [31:0] fast_tgt, slow_tgt;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0, upd_tgt = '0;
  logic        call = 1'b0, ret = 1'b0, flush = 1'b0;
  logic [31:0] call_addr = '0;
  logic [3:0]  flush_ptr = '0;
  logic [4:0]  flush_cnt = '0;
  logic        ras_valid;
  logic [31:0] ras_tgt;
  logic [3:0]  ras_ptr;
  logic [4:0]  ras_cnt;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ind_tgt_pred uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lookup_valid), .lookup_pc_i(lookup_pc),
    .fast_hit_o(fast_hit), .fast_tgt_o(fast_tgt),
    .slow_hit_o(slow_hit), .slow_tgt_o(slow_tgt),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_tgt_i(upd_tgt),
    .call_i(call), .call_addr_i(call_addr), .ret_i(ret),
    .flush_i(flush), .flush_ptr_i(flush_ptr), .flush_cnt_i(flush_cnt),
    .ras_valid_o(ras_valid), .ras_tgt_o(ras_tgt),
    .ras_ptr_o(ras_ptr), .ras_cnt_o(ras_cnt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual cycle %0d expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_tgt = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, input bit ef, input logic [31:0] eft,
                      input bit es, input logic [31:0] est, input string req);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_pc = pc;
    #1;
    check({req, " fast_hit"}, 32'(fast_hit), 32'(ef));
    if (ef) check({req, " fast_tgt"}, fast_tgt, eft);
    @(negedge clk);
    lookup_valid = 1'b0;
    #1;
    check({req, " slow_hit"}, 32'(slow_hit), 32'(es));
    if (es) check({req, " slow_tgt"}, slow_tgt, est);
  endtask

  task automatic push(input logic [31:0] a);
    @(negedge clk);
    call = 1'b1; call_addr = a;
    @(negedge clk);
    call = 1'b0;
    #1;
  endtask

  task automatic pop();
    @(negedge clk);
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    #1;
  endtask

  task automatic ras_chk(input bit v, input logic [31:0] t, input string req);
    check({req, " ras_valid"}, 32'(ras_valid), 32'(v));
    if (v) check({req, " ras_tgt"}, ras_tgt, t);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 fast", 32'(fast_hit), 32'd0);
    check("R1 slow", 32'(slow_hit), 32'd0);
    check("R1 ras_valid", 32'(ras_valid), 32'd0);
    check("R1 ptr", 32'(ras_ptr), 32'd0);
    check("R1 cnt", 32'(ras_cnt), 32'd0);
  endtask

  // R2, R3, R4, R5: fill first table so the victim lives only in the second
  task automatic t_two_level();
    logic [31:0] a;
    a = 32'h0000_2040;
    do_reset();
    look(a, 1'b0, '0, 1'b0, '0, "R3 cold miss");
    upd(a, 32'hA000_0040);
    look(a, 1'b1, 32'hA000_0040, 1'b0, '0, "R2 R5 fast after update");
    for (int i = 1; i <= 16; i++) upd(32'h0000_3000 + i, 32'hB000_0000 + i);
    look(a, 1'b0, '0, 1'b1, 32'hA000_0040, "R3 R5 second-level only");
    look(a, 1'b1, 32'hA000_0040, 1'b0, '0, "R4 promoted");
    look(32'h0000_3005, 1'b1, 32'hB000_0005, 1'b0, '0, "R2 other entry");
  endtask

  task automatic t_lru();
    do_reset();
    for (int i = 0; i < 16; i++) upd(32'h0000_5000 + i, 32'hC000_0000 + i);
    look(32'h0000_5000, 1'b1, 32'hC000_0000, 1'b0, '0, "R6 touch oldest");
    upd(32'h0000_5010, 32'hC000_0010);
    look(32'h0000_5000, 1'b1, 32'hC000_0000, 1'b0, '0, "R6 touched survives");
    look(32'h0000_5010, 1'b1, 32'hC000_0010, 1'b0, '0, "R6 newcomer held");
    look(32'h0000_5001, 1'b0, '0, 1'b1, 32'hC000_0001, "R6 LRU evicted");
  endtask

  task automatic t_overwrite();
    do_reset();
    upd(32'h0000_6001, 32'hD000_0001);
    look(32'h0000_6001, 1'b1, 32'hD000_0001, 1'b0, '0, "R7 first target");
    upd(32'h0000_6001, 32'hD000_0002);
    look(32'h0000_6001, 1'b1, 32'hD000_0002, 1'b0, '0, "R7 replaced target");
  endtask

  task automatic t_ras_basic();
    do_reset();
    push(32'h0000_1111);
    ras_chk(1'b1, 32'h0000_1111, "R8 push a");
    push(32'h0000_2222);
    ras_chk(1'b1, 32'h0000_2222, "R8 push b");
    pop();
    ras_chk(1'b1, 32'h0000_1111, "R8 pop to a");
    pop();
    ras_chk(1'b0, '0, "R9 empty after pops");
  endtask

  task automatic t_ras_wrap();
    do_reset();
    for (int i = 0; i <= 16; i++) push(32'hE000_0000 + i);
    ras_chk(1'b1, 32'hE000_0010, "R9 top after wrap");
    check("R9 saturated cnt", 32'(ras_cnt), 32'd16);
    check("R9 wrapped ptr", 32'(ras_ptr), 32'd1);
    for (int i = 15; i >= 1; i--) begin
      pop();
      ras_chk(1'b1, 32'hE000_0000 + i, "R9 pop order");
    end
    pop();
    ras_chk(1'b0, '0, "R9 empty after wrap");
    pop();
    check("R9 pop on empty cnt", 32'(ras_cnt), 32'd0);
    ras_chk(1'b0, '0, "R9 pop on empty valid");
    push(32'h0000_7777);
    ras_chk(1'b1, 32'h0000_7777, "R8 push after empty");
  endtask

  task automatic t_flush();
    do_reset();
    push(32'h0000_00AA);
    push(32'h0000_00BB);
    check("R10 ckpt ptr", 32'(ras_ptr), 32'd2);
    check("R10 ckpt cnt", 32'(ras_cnt), 32'd2);
    push(32'h0000_00CC);
    push(32'h0000_00DD);
    @(negedge clk);
    flush = 1'b1; flush_ptr = 4'd2; flush_cnt = 5'd2; call = 1'b1; call_addr = 32'h0000_0EEE;
    @(negedge clk);
    flush = 1'b0; call = 1'b0;
    #1;
    check("R10 ptr restored", 32'(ras_ptr), 32'd2);
    check("R10 cnt restored", 32'(ras_cnt), 32'd2);
    ras_chk(1'b1, 32'h0000_00BB, "R10 top after flush");
  endtask

  initial begin
    t_reset();
    t_two_level();
    t_lru();
    t_overwrite();
    t_ras_basic();
    t_ras_wrap();
    t_flush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule